// File: doc/BRIEF.md
# Floating-Point Rounding-Mode Resolver and Accrued-Flag Keeper

This block sits next to a floating-point arithmetic unit. When an operation issues, it works out which rounding mode the operation uses. The mode comes from the 3-bit mode field of the instruction, or from the dynamic rounding-mode register when that field asks for it. In the same cycle, the block flags any reserved or unusable mode as an illegal-instruction fault.

Every issued operation, faulted or not, enters a small in-order tracker. The tracker holds the resolved mode until the arithmetic unit signals completion. At completion the block does two things. It decides whether the destination register may be written. It ORs the unit's five raw exception bits into the sticky accrued-flag register, but only for an operation that did not fault.

Both control registers are reached through a simple select/write/read port. The dynamic rounding-mode register is 3 bits wide and the accrued-flag register is 5 bits wide.

Top module: `fprm_flag_ctrl`

## Requirements
- R1: With `iss_valid_i` high and `iss_rm_i` in 0..4, `fault_o` is low and `eff_mode_o` equals `iss_rm_i` in that cycle. The codes are 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 nearest with ties away from zero.
- R2: With `iss_rm_i` = 7 and the dynamic register holding 0..4, `eff_mode_o` equals the register value and `fault_o` is low.
- R3: With `iss_valid_i` high and `iss_rm_i` equal to 5 or 6, `fault_o` is high in the issue cycle.
- R4: With `iss_rm_i` = 7 and the dynamic register holding 5, 6 or 7, `fault_o` is high in the issue cycle.
- R5: `fault_o` is low in every cycle where `iss_valid_i` is low.
- R6: Operations complete in issue order. In the cycle `cmp_valid_i` is high, `head_mode_o` shows the resolved mode of the oldest outstanding operation. An issue and a completion may happen in the same cycle.
- R7: On completion of a non-faulted operation, `wb_en_o` is high in that cycle. From the next cycle, the accrued flags read as the old value ORed with `cmp_exc_i`. The bit positions are inexact 0, underflow 1, overflow 2, divide-by-zero 3, invalid 4.
- R8: On completion of a faulted operation, `wb_en_o` is low and the accrued flags do not change.
- R9: A completion never clears an accrued-flag bit. A completion with all-zero exception bits leaves the register unchanged.
- R10: Both registers reset to zero. `csr_sel_i` = 0 selects the dynamic mode register and 1 selects the accrued flags. A write to the mode register stores `csr_wdata_i[2:0]`. A write to the flags replaces all five bits. `csr_rdata_o` returns the selected register combinationally, with the mode zero-extended.
- R11: A flag write in the same cycle as a non-faulted completion leaves the written value ORed with `cmp_exc_i`.
- R12: A dynamic-mode issue in the same cycle as a mode-register write resolves against the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| iss_valid_i | input | 1 | An operation issues this cycle |
| iss_rm_i | input | 3 | Mode field of the issuing instruction |
| eff_mode_o | output | 3 | Resolved rounding mode of the issuing operation |
| fault_o | output | 1 | Illegal-instruction fault for the issuing operation |
| cmp_valid_i | input | 1 | The oldest outstanding operation completes |
| cmp_exc_i | input | 5 | Raw exception bits of the completing operation |
| head_mode_o | output | 3 | Resolved mode of the oldest outstanding operation |
| wb_en_o | output | 1 | Destination write permitted for the completing operation |
| csr_wen_i | input | 1 | Register write strobe |
| csr_sel_i | input | 1 | Register select: 0 mode, 1 flags |
| csr_wdata_i | input | 5 | Register write data |
| csr_rdata_o | output | 5 | Selected register contents |

## Verification
The assertions take three things for granted about the environment. Completions arrive only while an operation is outstanding. No more than the tracker depth of operations are ever in flight. A completion never refers to an operation issued in that same cycle. The stimulus keeps to these limits by construction: it issues at most four operations before draining them, and it raises the completion strobe only for operations a scoreboard queue already holds. Same-cycle collisions are driven on purpose so that the ordering rules are exercised at the ports: issue with completion, flag write with merge, and mode write with dynamic issue.

// File: rtl/fprm_pkg.sv
package fprm_pkg;
  localparam int RM_W   = 3;
  localparam int FLAG_W = 5;

  // Rounding-mode codes; values above MODE_MAX are unusable as a final mode.
  localparam logic [RM_W-1:0] MODE_NEAR_EVEN = 3'd0;
  localparam logic [RM_W-1:0] MODE_TO_ZERO   = 3'd1;
  localparam logic [RM_W-1:0] MODE_DOWN      = 3'd2;
  localparam logic [RM_W-1:0] MODE_UP        = 3'd3;
  localparam logic [RM_W-1:0] MODE_NEAR_MAX  = 3'd4;
  localparam logic [RM_W-1:0] MODE_MAX       = MODE_NEAR_MAX;
  localparam logic [RM_W-1:0] MODE_DYNAMIC   = 3'd7;

  // Accrued-flag bit positions.
  localparam int FLG_INEXACT   = 0;
  localparam int FLG_UNDERFLOW = 1;
  localparam int FLG_OVERFLOW  = 2;
  localparam int FLG_DIVZERO   = 3;
  localparam int FLG_INVALID   = 4;

  typedef struct packed {
    logic [RM_W-1:0] mode;
    logic            bad;
  } trk_ent_t;
endpackage

// File: rtl/fprm_resolve.sv
module fprm_resolve
  import fprm_pkg::*;
(
  input  logic [RM_W-1:0] rm_i,
  input  logic [RM_W-1:0] dyn_i,
  output logic [RM_W-1:0] mode_o,
  output logic            illegal_o
);
  logic [RM_W-1:0] src;

  always_comb begin
    src       = (rm_i == MODE_DYNAMIC) ? dyn_i : rm_i;
    illegal_o = (src > MODE_MAX);
    mode_o    = illegal_o ? MODE_NEAR_EVEN : src;
  end
endmodule

// File: rtl/fprm_track.sv
module fprm_track
  import fprm_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  trk_ent_t push_ent_i,
  input  logic     pop_i,
  output trk_ent_t head_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  trk_ent_t         ent_q [DEPTH];

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push_i) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop_i)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ld;
    assign ld = push_i && (wr_q == PTR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ent_q[i] <= '0;
      else if (ld)  ent_q[i] <= push_ent_i;
    end
  end

  assign head_o = ent_q[rd_q];
endmodule

// File: rtl/fprm_csr.sv
module fprm_csr
  import fprm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_i,
  input  logic              sel_i,
  input  logic [FLAG_W-1:0] wdata_i,
  input  logic              merge_i,
  input  logic [FLAG_W-1:0] merge_bits_i,
  output logic [RM_W-1:0]   dyn_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [RM_W-1:0]   dyn_q, dyn_d;
  logic [FLAG_W-1:0] flg_q, flg_d;
  logic              dyn_en, flg_en;

  always_comb begin
    dyn_en = wen_i && !sel_i;
    dyn_d  = wdata_i[RM_W-1:0];
    // Software write first, merge applied on top of it.
    flg_d  = (wen_i && sel_i) ? wdata_i : flg_q;
    if (merge_i) flg_d = flg_d | merge_bits_i;
    flg_en = (wen_i && sel_i) || merge_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dyn_q <= '0;
    else if (dyn_en) dyn_q <= dyn_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flg_q <= '0;
    else if (flg_en) flg_q <= flg_d;
  end

  assign dyn_o   = dyn_q;
  assign flags_o = flg_q;
endmodule

// File: rtl/fprm_flag_ctrl.sv
module fprm_flag_ctrl
  import fprm_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [RM_W-1:0]   iss_rm_i,
  output logic [RM_W-1:0]   eff_mode_o,
  output logic              fault_o,
  input  logic              cmp_valid_i,
  input  logic [FLAG_W-1:0] cmp_exc_i,
  output logic [RM_W-1:0]   head_mode_o,
  output logic              wb_en_o,
  input  logic              csr_wen_i,
  input  logic              csr_sel_i,
  input  logic [FLAG_W-1:0] csr_wdata_i,
  output logic [FLAG_W-1:0] csr_rdata_o
);
  logic [RM_W-1:0]   frm_w;
  logic [FLAG_W-1:0] fflags_w;
  logic [RM_W-1:0]   res_mode;
  logic              res_bad;
  trk_ent_t          new_ent, head_ent;
  logic              merge_en;

  fprm_resolve u_res (
    .rm_i     (iss_rm_i),
    .dyn_i    (frm_w),
    .mode_o   (res_mode),
    .illegal_o(res_bad)
  );

  always_comb begin
    new_ent.mode = res_mode;
    new_ent.bad  = res_bad;
  end

  fprm_track #(.DEPTH(DEPTH)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (iss_valid_i),
    .push_ent_i(new_ent),
    .pop_i     (cmp_valid_i),
    .head_o    (head_ent)
  );

  assign merge_en = cmp_valid_i && !head_ent.bad;

  fprm_csr u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wen_i       (csr_wen_i),
    .sel_i       (csr_sel_i),
    .wdata_i     (csr_wdata_i),
    .merge_i     (merge_en),
    .merge_bits_i(cmp_exc_i),
    .dyn_o       (frm_w),
    .flags_o     (fflags_w)
  );

  assign eff_mode_o  = res_mode;
  assign fault_o     = iss_valid_i && res_bad;
  assign head_mode_o = head_ent.mode;
  assign wb_en_o     = merge_en;
  assign csr_rdata_o = csr_sel_i ? fflags_w : {{(FLAG_W-RM_W){1'b0}}, frm_w};
endmodule

// File: rtl/fprm_flag_ctrl_chk.sv
module fprm_flag_ctrl_chk
  import fprm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic [RM_W-1:0]   iss_rm,
  input logic [RM_W-1:0]   eff_mode,
  input logic              fault,
  input logic              cmp_valid,
  input logic [FLAG_W-1:0] exc,
  input logic              wb_en,
  input logic              csr_wen,
  input logic              csr_sel,
  input logic [RM_W-1:0]   frm,
  input logic [FLAG_W-1:0] fflags
);
  p_static_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_rm <= MODE_MAX) |-> (!fault && eff_mode == iss_rm));

  p_dyn_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_rm == MODE_DYNAMIC && frm <= MODE_MAX) |-> (!fault && eff_mode == frm));

  p_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (iss_rm == 3'd5 || iss_rm == 3'd6)) |-> fault);

  p_dyn_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_rm == MODE_DYNAMIC && frm > MODE_MAX) |-> fault);

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !fault);

  p_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !(csr_wen && csr_sel)) |=> (fflags == ($past(fflags) | $past(exc))));

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_en && !(csr_wen && csr_sel)) |=> $stable(fflags));

  p_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |-> !wb_en);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_wen && csr_sel) |=> ((fflags & $past(fflags)) == $past(fflags)));
endmodule

bind fprm_flag_ctrl fprm_flag_ctrl_chk u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .iss_valid(iss_valid_i),
  .iss_rm   (iss_rm_i),
  .eff_mode (eff_mode_o),
  .fault    (fault_o),
  .cmp_valid(cmp_valid_i),
  .exc      (cmp_exc_i),
  .wb_en    (wb_en_o),
  .csr_wen  (csr_wen_i),
  .csr_sel  (csr_sel_i),
  .frm      (frm_w),
  .fflags   (fflags_w)
);

// File: tb/sim_fprm_flag_ctrl.sv
module sim_fprm_flag_ctrl;
  localparam time CLK_P = 4ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       iss_valid, cmp_valid, csr_wen, csr_sel;
  logic [2:0] iss_rm, eff_mode, head_mode;
  logic [4:0] cmp_exc, csr_wdata, csr_rdata;
  logic       fault, wb_en;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [2:0] mode;
    logic       bad;
  } exp_t;

  exp_t       iss_q[$];
  exp_t       fly_q[$];
  logic [2:0] frm_m = 3'd0;
  logic [4:0] ff_m  = 5'd0;
  string      cur_tag = "";

  always #(CLK_P/2) clk = ~clk;

  fprm_flag_ctrl u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .iss_valid_i(iss_valid),
    .iss_rm_i   (iss_rm),
    .eff_mode_o (eff_mode),
    .fault_o    (fault),
    .cmp_valid_i(cmp_valid),
    .cmp_exc_i  (cmp_exc),
    .head_mode_o(head_mode),
    .wb_en_o    (wb_en),
    .csr_wen_i  (csr_wen),
    .csr_sel_i  (csr_sel),
    .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Driver: one cycle of stimulus; expectations for issues go to the scoreboard.
  task automatic cyc(input logic iv, input logic [2:0] rm, input logic cv, input logic [4:0] ex,
                     input logic we, input logic sl, input logic [4:0] wd, input string tag);
    exp_t e;
    logic [2:0] src;
    @(negedge clk);
    cur_tag = tag;
    if (iv) begin
      src    = (rm == 3'd7) ? frm_m : rm;
      e.bad  = (src > 3'd4);
      e.mode = e.bad ? 3'd0 : src;
      iss_q.push_back(e);
      fly_q.push_back(e);
    end
    iss_valid = iv; iss_rm = rm; cmp_valid = cv; cmp_exc = ex;
    csr_wen = we; csr_sel = sl; csr_wdata = wd;
    @(posedge clk);
    #1;
    iss_valid = 1'b0; cmp_valid = 1'b0; csr_wen = 1'b0; cmp_exc = '0;
  endtask

  task automatic rd(input logic sl, input logic [4:0] exp, input string req);
    @(negedge clk);
    csr_sel = sl;
    #1;
    chk(csr_rdata == exp, req, csr_rdata, exp);
  endtask

  // Monitor: pops scoreboard items as results appear and tracks the flag model.
  always @(negedge clk) begin
    exp_t e;
    logic [4:0] nff;
    #1;
    if (rst_n) begin
      if (iss_valid) begin
        e = iss_q.pop_front();
        chk(fault == e.bad, {cur_tag, " fault"}, fault, e.bad);
        if (!e.bad) chk(eff_mode == e.mode, {cur_tag, " mode"}, eff_mode, e.mode);
      end else begin
        chk(!fault, "R5 idle fault", fault, 0);
      end
      nff = ff_m;
      if (csr_wen && csr_sel) nff = csr_wdata;
      if (cmp_valid) begin
        e = fly_q.pop_front();
        chk(wb_en == !e.bad, {cur_tag, " wb_en"}, wb_en, !e.bad);
        if (!e.bad) begin
          chk(head_mode == e.mode, {cur_tag, " R6 head mode"}, head_mode, e.mode);
          nff = nff | cmp_exc;
        end
      end else begin
        chk(!wb_en, "R8 wb idle", wb_en, 0);
      end
      if (csr_wen && !csr_sel) frm_m = csr_wdata[2:0];
      ff_m = nff;
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    iss_valid = 1'b0; iss_rm = '0; cmp_valid = 1'b0; cmp_exc = '0;
    csr_wen = 1'b0; csr_sel = 1'b0; csr_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    rd(1'b0, 5'h00, "R10 reset frm");
    rd(1'b1, 5'h00, "R10 reset fflags");

    // R1 static modes, R6 in-order completion, R7 merge
    cyc(1, 3'd0, 0, 5'h00, 0, 0, 5'h00, "R1 rm0");
    cyc(1, 3'd1, 0, 5'h00, 0, 0, 5'h00, "R1 rm1");
    cyc(1, 3'd2, 0, 5'h00, 0, 0, 5'h00, "R1 rm2");
    cyc(0, 3'd0, 1, 5'h01, 0, 0, 5'h00, "R7 done0");
    cyc(0, 3'd0, 1, 5'h00, 0, 0, 5'h00, "R7 done1");
    cyc(0, 3'd0, 1, 5'h04, 0, 0, 5'h00, "R7 done2");
    rd(1'b1, 5'h05, "R7 fflags");
    cyc(1, 3'd3, 0, 5'h00, 0, 0, 5'h00, "R1 rm3");
    cyc(1, 3'd4, 0, 5'h00, 0, 0, 5'h00, "R1 rm4");
    cyc(0, 3'd0, 1, 5'h00, 0, 0, 5'h00, "R7 done3");
    cyc(0, 3'd0, 1, 5'h08, 0, 0, 5'h00, "R7 done4");
    rd(1'b1, 5'h0D, "R7 fflags divzero");

    // R3 reserved field values, R8 no flag update
    cyc(1, 3'd5, 0, 5'h00, 0, 0, 5'h00, "R3 rm5");
    cyc(1, 3'd6, 0, 5'h00, 0, 0, 5'h00, "R3 rm6");
    cyc(0, 3'd0, 1, 5'h1F, 0, 0, 5'h00, "R8 done5");
    cyc(0, 3'd0, 1, 5'h1F, 0, 0, 5'h00, "R8 done6");
    rd(1'b1, 5'h0D, "R8 fflags unchanged");

    // R10 frm write keeps 3 bits, R2 dynamic, R9 zero merge
    cyc(0, 3'd0, 0, 5'h00, 1, 0, 5'h1B, "R10 wr frm");
    rd(1'b0, 5'h03, "R10 frm 3 bits");
    cyc(1, 3'd7, 0, 5'h00, 0, 0, 5'h00, "R2 dyn3");
    cyc(0, 3'd0, 1, 5'h00, 0, 0, 5'h00, "R9 done dyn");
    rd(1'b1, 5'h0D, "R9 sticky");

    // R4 dynamic with unusable frm
    cyc(0, 3'd0, 0, 5'h00, 1, 0, 5'h06, "R4 wr6");
    cyc(1, 3'd7, 0, 5'h00, 0, 0, 5'h00, "R4 dyn6");
    cyc(0, 3'd0, 0, 5'h00, 1, 0, 5'h07, "R4 wr7");
    cyc(1, 3'd7, 0, 5'h00, 0, 0, 5'h00, "R4 dyn7");
    cyc(0, 3'd0, 0, 5'h00, 1, 0, 5'h05, "R4 wr5");
    cyc(1, 3'd7, 0, 5'h00, 0, 0, 5'h00, "R4 dyn5");
    cyc(0, 3'd0, 1, 5'h1F, 0, 0, 5'h00, "R8 drain a");
    cyc(0, 3'd0, 1, 5'h1F, 0, 0, 5'h00, "R8 drain b");
    cyc(0, 3'd0, 1, 5'h1F, 0, 0, 5'h00, "R8 drain c");
    rd(1'b1, 5'h0D, "R8 fflags after dyn faults");

    // R12 write and dynamic issue together use old frm (5)
    cyc(1, 3'd7, 0, 5'h00, 1, 0, 5'h01, "R12 old frm");
    // R6 issue and completion in one cycle
    cyc(1, 3'd7, 1, 5'h1F, 0, 0, 5'h00, "R6 overlap");
    cyc(0, 3'd0, 1, 5'h10, 0, 0, 5'h00, "R7 invalid");
    rd(1'b1, 5'h1D, "R7 invalid set");

    // R10 flag write replaces, R11 write with merge
    cyc(0, 3'd0, 0, 5'h00, 1, 1, 5'h02, "R10 wr ff");
    rd(1'b1, 5'h02, "R10 fflags replaced");
    cyc(1, 3'd0, 0, 5'h00, 0, 0, 5'h00, "R11 issue");
    cyc(0, 3'd0, 1, 5'h01, 1, 1, 5'h08, "R11 wr+merge");
    rd(1'b1, 5'h09, "R11 merge on top");

    // R6 full depth, order kept
    cyc(1, 3'd3, 0, 5'h00, 0, 0, 5'h00, "R6 f0");
    cyc(1, 3'd1, 0, 5'h00, 0, 0, 5'h00, "R6 f1");
    cyc(1, 3'd4, 0, 5'h00, 0, 0, 5'h00, "R6 f2");
    cyc(1, 3'd2, 0, 5'h00, 0, 0, 5'h00, "R6 f3");
    for (int i = 0; i < 4; i++) cyc(0, 3'd0, 1, 5'h00, 0, 0, 5'h00, "R6 drain");
    rd(1'b1, 5'h09, "R9 fflags kept");
    rd(1'b0, 5'h01, "R12 frm new value");

    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule